// File: doc/BRIEF.md
# Freezable Auto-Loaded Capability Register

This block holds one 8-bit control word describing what the far end of a serial link can do. Four capability flags live in it: a request for the frequency training pattern, a request for the equalization training pattern, a dual-link support flag and a channel select. Once the receiver reports lock, the control channel delivers these flags as a 4-bit word together with a one-cycle valid strobe. The register loads that word into the flags on its own. Software can also read the whole word and write it.

The top bit is an ownership switch. Only software can change it. While it is set, words from the channel are dropped, so values written by software stay in place. The remaining bits (6, 1 and 0) are not implemented. They read as zero.

Lock counts as detected only after `rx_lock` has been high at two consecutive clock edges. A remote word that arrives in the very first cycle of lock is therefore not taken. A build-time option limits the register to a single auto-load per lock episode. The default accepts every qualified strobe.

Top module: `capreg_top`

## Requirements
- R1: After reset, and while reset is held, `sw_rdata` reads 0x00 and every flag output is 0.
- R2: When `sw_we` is high at a clock edge, bits 7, 5, 4, 3 and 2 of `sw_rdata` take the matching bits of `sw_wdata` from that edge onward.
- R3: Bits 6, 1 and 0 of `sw_rdata` always read 0, whatever value is written.
- R4: A clock edge at which `rmt_valid` is high, lock is qualified and bit 7 is 0 loads `rmt_caps[3:0]` into `sw_rdata[5:2]`. The mapping is `rmt_caps[3]` to bit 5 (frequency training), `[2]` to bit 4 (equalization training), `[1]` to bit 3 (dual-link support) and `[0]` to bit 2 (channel: 0 means primary, 1 means secondary).
- R5: A `rmt_valid` strobe is ignored while `rx_lock` is low, and also in the first cycle of lock (when `rx_lock` was low at the previous edge).
- R6: While bit 7 (freeze) is 1, `rmt_valid` strobes do not change the register.
- R7: Bit 7 changes only through a software write. An auto-load never alters it.
- R8: When a software write and a qualified auto-load fall on the same edge, the register takes the software value.
- R9: `freeze_o` always equals `sw_rdata[7]`, and `caps_o[3:0]` always equals `sw_rdata[5:2]`.
- R10: With neither `sw_we` nor a qualified `rmt_valid`, the register holds its value, even while `rx_lock` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Register read value |
| rx_lock | input | 1 | Receiver lock indication |
| rmt_valid | input | 1 | One-cycle strobe marking a remote capability word |
| rmt_caps | input | 4 | Remote capability word (mapping in R4) |
| freeze_o | output | 1 | Current freeze (ownership) bit |
| caps_o | output | 4 | Current capability flags, same order as `rmt_caps` |

## Verification
Every piece of state in this block reaches the read port one cycle after it changes. A wrong flop shows up at the next sampling point, as a mismatch in `sw_rdata` and in the flag outputs. A faulty lock qualifier shows up only at the boundaries: a strobe in the first lock cycle that gets loaded, or a strobe that is dropped right after lock. The bench therefore drives strobes at exactly those edges. A freeze bit that fails to gate, or that is touched by auto-load, shows up at the first strobe after the freeze is set.

// File: rtl/capreg_pkg.sv
package capreg_pkg;

   // Source chosen for a storage bit at the next clock edge.
   typedef enum logic [1:0] {
      SRC_HOLD = 2'd0,
      SRC_SW   = 2'd1,
      SRC_RMT  = 2'd2
   } src_e;

   // Build a mask with `width` ones starting at bit `lsb`.
   function automatic logic [31:0] field_mask(input int unsigned lsb, input int unsigned width);
      logic [31:0] m;
      m = '0;
      for (int unsigned k = 0; k < 32; k++) begin
         if (k >= lsb && k < lsb + width) m[k] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/capreg_bit.sv
module capreg_bit
   import capreg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  src_e src_i,
   input  logic sw_d_i,
   input  logic rmt_d_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= 1'b0;
      end else begin
         unique case (src_i)
            SRC_SW:  q_o <= sw_d_i;
            SRC_RMT: q_o <= rmt_d_i;
            default: q_o <= q_o;
         endcase
      end
   end

endmodule

// File: rtl/capreg_lock_qual.sv
module capreg_lock_qual #(
   parameter bit ONE_SHOT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_lock,
   input  logic rmt_valid,
   input  logic frozen,
   output logic load_o
);

   logic lock_q;
   logic lock_held;
   logic lock_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= 1'b0;
      else        lock_q <= rx_lock;
   end

   assign lock_held = rx_lock & lock_q;
   assign lock_rise = rx_lock & ~lock_q;

   generate
      if (ONE_SHOT) begin : g_one_shot
         logic armed_q;
         logic grant;
         assign grant  = rmt_valid & lock_held & ~frozen & armed_q;
         assign load_o = grant;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          armed_q <= 1'b0;
            else if (!rx_lock)   armed_q <= 1'b0;
            else if (lock_rise)  armed_q <= 1'b1;
            else if (grant)      armed_q <= 1'b0;
         end
      end else begin : g_level
         logic unused_rise;
         assign unused_rise = lock_rise;
         assign load_o = rmt_valid & lock_held & ~frozen;
      end
   endgenerate

endmodule

// File: rtl/capreg_top.sv
module capreg_top
   import capreg_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CAP_W    = 4,
   parameter int unsigned CAP_LSB  = 2,
   parameter int unsigned FRZ_POS  = 7,
   parameter bit          ONE_SHOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [7:0]        sw_wdata,
   output logic [7:0]        sw_rdata,
   input  logic              rx_lock,
   input  logic              rmt_valid,
   input  logic [3:0]        rmt_caps,
   output logic              freeze_o,
   output logic [3:0]        caps_o
);

   localparam logic [31:0] CAP_MASK32 = field_mask(CAP_LSB, CAP_W);
   localparam logic [31:0] FRZ_MASK32 = field_mask(FRZ_POS, 1);
   localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'(CAP_MASK32 | FRZ_MASK32);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("capreg_top: port widths assume DATA_W of 8");
      end
      if (CAP_W != 4) begin : g_bad_cap_w
         $error("capreg_top: port widths assume CAP_W of 4");
      end
      if (FRZ_POS >= DATA_W) begin : g_bad_frz
         $error("capreg_top: freeze position outside the word");
      end
      if (CAP_LSB + CAP_W > DATA_W) begin : g_bad_cap
         $error("capreg_top: capability field outside the word");
      end
      if (FRZ_POS >= CAP_LSB && FRZ_POS < CAP_LSB + CAP_W) begin : g_overlap
         $error("capreg_top: freeze bit overlaps capability field");
      end
   endgenerate

   logic             frz_q;
   logic [CAP_W-1:0] cap_q;
   logic             load_en;
   src_e             cap_src;
   src_e             frz_src;

   capreg_lock_qual #(
      .ONE_SHOT (ONE_SHOT)
   ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_lock   (rx_lock),
      .rmt_valid (rmt_valid),
      .frozen    (frz_q),
      .load_o    (load_en)
   );

   always_comb begin
      if (sw_we)        cap_src = SRC_SW;
      else if (load_en) cap_src = SRC_RMT;
      else              cap_src = SRC_HOLD;
      frz_src = sw_we ? SRC_SW : SRC_HOLD;
   end

   capreg_bit u_frz (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (frz_src),
      .sw_d_i  (sw_wdata[FRZ_POS]),
      .rmt_d_i (frz_q),
      .q_o     (frz_q)
   );

   generate
      for (genvar i = 0; i < CAP_W; i++) begin : g_cap
         capreg_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (cap_src),
            .sw_d_i  (sw_wdata[CAP_LSB + i]),
            .rmt_d_i (rmt_caps[i]),
            .q_o     (cap_q[i])
         );
      end
   endgenerate

   logic unused_wr_bits;
   assign unused_wr_bits = ^(sw_wdata & ~IMPL_MASK);

   always_comb begin
      sw_rdata                   = '0;
      sw_rdata[FRZ_POS]          = frz_q;
      sw_rdata[CAP_LSB +: CAP_W] = cap_q;
   end

   assign freeze_o = frz_q;
   assign caps_o   = cap_q;

endmodule

// File: rtl/capreg_chk.sv
module capreg_chk #(
   parameter bit ONE_SHOT = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sw_we,
   input logic [7:0] sw_wdata,
   input logic [7:0] sw_rdata,
   input logic       rx_lock,
   input logic       rmt_valid,
   input logic [3:0] rmt_caps,
   input logic       freeze_o,
   input logic [3:0] caps_o
);

   logic lock_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_seen <= 1'b0;
      else        lock_seen <= rx_lock;
   end

   logic qual;
   assign qual = rmt_valid & rx_lock & lock_seen;

   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> (sw_rdata == 8'h00));

   p_sw_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we |=> (sw_rdata == ($past(sw_wdata) & 8'hBC)));

   p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rdata & 8'h43) == 8'h00);

   generate
      if (!ONE_SHOT) begin : g_level_chk
         p_autoload_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (qual && !freeze_o && !sw_we) |=> (sw_rdata[5:2] == $past(rmt_caps)));
      end
   endgenerate

   p_unqualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we && !qual) |=> $stable(sw_rdata));

   p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_o && !sw_we) |=> $stable(sw_rdata));

   p_freeze_sw_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_we |=> $stable(freeze_o));

   p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && qual) |=> (sw_rdata[5:2] == $past(sw_wdata[5:2])));

   always_comb begin
      if (rst_n) begin
         p_flags_mirror_r9: assert ({freeze_o, caps_o} == {sw_rdata[7], sw_rdata[5:2]});
      end
   end

endmodule

bind capreg_top capreg_chk #(
   .ONE_SHOT (ONE_SHOT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sw_we     (sw_we),
   .sw_wdata  (sw_wdata),
   .sw_rdata  (sw_rdata),
   .rx_lock   (rx_lock),
   .rmt_valid (rmt_valid),
   .rmt_caps  (rmt_caps),
   .freeze_o  (freeze_o),
   .caps_o    (caps_o)
);

// File: tb/capreg_top_tb_top.sv
`timescale 1ns/1ps
module capreg_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_we = 1'b0;
   logic [7:0] sw_wdata = 8'h00;
   logic [7:0] sw_rdata;
   logic       rx_lock = 1'b0;
   logic       rmt_valid = 1'b0;
   logic [3:0] rmt_caps = 4'h0;
   logic       freeze_o;
   logic [3:0] caps_o;

   always #2.5 clk = ~clk;

   capreg_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_we     (sw_we),
      .sw_wdata  (sw_wdata),
      .sw_rdata  (sw_rdata),
      .rx_lock   (rx_lock),
      .rmt_valid (rmt_valid),
      .rmt_caps  (rmt_caps),
      .freeze_o  (freeze_o),
      .caps_o    (caps_o)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   string phase  = "R1";

   // Reference model: expected register word and remembered lock level.
   logic [7:0] exp_word;
   logic       exp_lock_prev;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_word      <= 8'h00;
         exp_lock_prev <= 1'b0;
      end else begin
         exp_lock_prev <= rx_lock;
         if (sw_we) begin
            exp_word <= {sw_wdata[7], 1'b0, sw_wdata[5:2], 2'b00};
         end else if (rmt_valid && rx_lock && exp_lock_prev && !exp_word[7]) begin
            exp_word <= {exp_word[7], 1'b0, rmt_caps, 2'b00};
         end
      end
   end

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         check(phase, sw_rdata, exp_word);
         check("R9", {3'b000, freeze_o, caps_o}, {3'b000, exp_word[7], exp_word[5:2]});
         check("R3", sw_rdata & 8'h43, 8'h00);
      end
   end

   task automatic step(input logic we, input logic [7:0] wd, input logic lk,
                       input logic vld, input logic [3:0] cp);
      @(negedge clk);
      sw_we     = we;
      sw_wdata  = wd;
      rx_lock   = lk;
      rmt_valid = vld;
      rmt_caps  = cp;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      phase = "R2";
      step(1, 8'hFF, 0, 0, 4'h0);
      step(1, 8'h00, 0, 0, 4'h0);
      step(1, 8'hA5, 0, 0, 4'h0);
      step(1, 8'h5A, 0, 0, 4'h0);
      step(0, 8'h00, 0, 0, 4'h0);

      phase = "R3";
      step(1, 8'h43, 0, 0, 4'h0);
      step(0, 8'h00, 0, 0, 4'h0);
      step(1, 8'h00, 0, 0, 4'h0);

      phase = "R10";
      step(0, 8'h00, 1, 0, 4'hF);
      step(0, 8'h00, 1, 0, 4'hF);
      step(0, 8'h00, 1, 0, 4'hF);

      phase = "R4";
      step(0, 8'h00, 1, 1, 4'hA);
      step(0, 8'h00, 1, 1, 4'h5);
      step(0, 8'h00, 1, 1, 4'hF);
      step(0, 8'h00, 1, 1, 4'h1);
      step(0, 8'h00, 1, 0, 4'h8);

      phase = "R5";
      step(0, 8'h00, 0, 1, 4'h6);
      step(0, 8'h00, 0, 1, 4'h6);
      step(0, 8'h00, 1, 1, 4'h6);
      step(0, 8'h00, 1, 1, 4'h9);
      step(0, 8'h00, 1, 0, 4'h0);

      phase = "R6";
      step(1, 8'h80, 1, 0, 4'h0);
      step(0, 8'h00, 1, 1, 4'hF);
      step(0, 8'h00, 1, 1, 4'h3);
      step(1, 8'hA0, 1, 0, 4'h0);
      step(0, 8'h00, 1, 1, 4'h0);
      step(0, 8'h00, 1, 0, 4'h0);

      phase = "R7";
      step(1, 8'h00, 1, 0, 4'h0);
      step(0, 8'h00, 1, 1, 4'hF);
      step(0, 8'h00, 1, 1, 4'h0);
      step(0, 8'h00, 1, 0, 4'h0);

      phase = "R8";
      step(1, 8'h88, 1, 1, 4'hF);
      step(1, 8'h14, 1, 1, 4'h0);
      step(1, 8'h00, 1, 1, 4'hA);
      step(0, 8'h00, 1, 0, 4'h0);

      phase = "R9";
      for (int n = 0; n < 400; n++) begin
         step(($urandom % 6) == 0, 8'($urandom), ($urandom % 5) != 0,
              ($urandom % 2) == 0, 4'($urandom));
      end

      phase = "R1";
      @(posedge clk);
      #1 rst_n = 1'b0;
      step(0, 8'h00, 1, 1, 4'hF);
      step(0, 8'h00, 1, 1, 4'hF);
      @(posedge clk);
      #1 rst_n = 1'b1;
      step(0, 8'h00, 0, 0, 4'h0);
      step(0, 8'h00, 0, 0, 4'h0);
      @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

endmodule